// File: doc/BRIEF.md
# Buffered-Program Command Interface for a NOR-Style Flash Array

This block sits between a synchronous word bus and a small flash-like storage array. It turns bus write cycles into a buffered-program transaction. A setup command opens the transaction. The next write gives the word count, encoded as count minus one. Then come the data words, which land in a 32-entry holding buffer. A confirm command hands the buffer to an internal write engine, which programs the array one word at a time.

Reads return one of two things, depending on the current read mode: the status word or array contents. The status word carries a ready flag and a sticky sequence-error flag. Any malformed step ends the transaction and raises the error flag:

- a count that is too large;
- a data address outside the start block or outside the loaded window;
- a wrong confirm code or an out-of-block confirm.

The error flag stays set until software writes the clear-status command. Programming behaves like NOR cells: each array word is ANDed with the buffered value, so untouched buffer slots, which hold all-ones, leave the array unchanged.

Top module: `bufprog_flash`

## Requirements
- R1: After reset, ready_o is 1 and err_o is 0. The block is in array read mode, and every array word reads 16'hFFFF.
- R2: Writing 8'hE8 while idle starts a transaction and selects status read mode. A status read returns bit 7 as ready and bit 4 as the error flag, with all other bits 0, at any address.
- R3: The write after setup takes the count from data[7:0] as N-1 (0 means one word). A value above 8'h1F sets the error flag and returns to idle.
- R4: The first data write fixes the start address. Each later data write must be in the same 64-word block (address bits [7:6]) and at an offset from start of at most N-1. Otherwise the error flag is set and nothing is programmed.
- R5: After N data writes, a write of 8'hD0 to an address in the start block begins programming. Any other value, or another block, sets the error flag and leaves the array unchanged.
- R6: Programming holds ready_o and status bit 7 at 0 for exactly 8*N clock cycles after the confirm edge. Both then return to 1.
- R7: Programming ANDs buffer slot i into array word start+i for i in 0..N-1. Slots that were not loaded hold all-ones.
- R8: Writing 8'hFF while idle or busy selects array read mode, where a read returns the addressed array word one cycle later.
- R9: The error flag persists through other commands and is cleared only by 8'h50, which also works while busy.
- R10: While programming, every written value other than 8'hFF and 8'h50 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 16 | Write data; commands use bits 7:0 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data valid the next cycle |
| bus_rdata | output | 16 | Registered read data (status or array) |
| ready_o | output | 1 | 1 when the write engine is idle |
| err_o | output | 1 | Sticky sequence-error flag |

## Verification
The hardest case to reach is a command that arrives while the engine is busy, because the busy window depends on N and closes on its own. The bench counts the window cycle by cycle after a directed confirm. It then issues a setup command and a clear-status command inside the window. After ready returns, it writes a value that would be an illegal count if the setup had been taken. The error flag must still be clear. Random transactions vary N, start offset, write order and confirm address, and add error paths, against a bench-side AND model of the array.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_PROG
    } bp_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_READARR = 8'hFF;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;

    localparam int STAT_RDY_BIT = 7;
    localparam int STAT_ERR_BIT = 4;
endpackage

// File: rtl/bp_wbuf.sv
module bp_wbuf #(
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [BUF_DEPTH];

    for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_q[g] <= '1;
            end else if (we && waddr == IDX_W'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/bp_array.sv
module bp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
        end else if (we) begin
            cell_q[waddr] <= cell_q[waddr] & wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/bp_seq.sv
module bp_seq
    import bp_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int BUF_DEPTH    = 32,
    parameter int BLK_W        = 6,
    parameter int CYC_PER_WORD = 8,
    localparam int IDX_W       = $clog2(BUF_DEPTH),
    localparam int TMR_W       = (CYC_PER_WORD > 1) ? $clog2(CYC_PER_WORD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ready_o,
    output logic              err_o,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_waddr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic [IDX_W-1:0]  buf_raddr,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata
);
    localparam logic [7:0]       MAX_CNT  = 8'(BUF_DEPTH - 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CYC_PER_WORD - 1);

    typedef struct packed {
        bp_state_e         st;
        logic              rd_stat;
        logic              err;
        logic [ADDR_W-1:0] start;
        logic [IDX_W-1:0]  cnt;
        logic [IDX_W-1:0]  nload;
        logic [IDX_W-1:0]  idx;
        logic [TMR_W-1:0]  tmr;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic [7:0]        cmd;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] cnt_ext;
    logic [ADDR_W-1:0] idx_ext;
    logic              same_blk;
    logic              in_win;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        cmd      = bus_wdata[7:0];
        off      = bus_addr - s_q.start;
        cnt_ext  = {{(ADDR_W-IDX_W){1'b0}}, s_q.cnt};
        idx_ext  = {{(ADDR_W-IDX_W){1'b0}}, s_q.idx};
        same_blk = bus_addr[ADDR_W-1:BLK_W] == s_q.start[ADDR_W-1:BLK_W];
        in_win   = same_blk && (off <= cnt_ext);

        stat_word               = '0;
        stat_word[STAT_RDY_BIT] = (s_q.st != ST_PROG);
        stat_word[STAT_ERR_BIT] = s_q.err;

        s_d       = s_q;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = bus_wdata;
        arr_we    = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (bus_we) begin
                    if (cmd == CMD_SETUP) begin
                        s_d.st      = ST_COUNT;
                        s_d.rd_stat = 1'b1;
                    end else if (cmd == CMD_READARR) begin
                        s_d.rd_stat = 1'b0;
                    end else if (cmd == CMD_CLRSTAT) begin
                        s_d.err = 1'b0;
                    end
                end
            end
            ST_COUNT: begin
                if (bus_we) begin
                    if (cmd > MAX_CNT) begin
                        s_d.err     = 1'b1;
                        s_d.st      = ST_IDLE;
                        s_d.rd_stat = 1'b1;
                    end else begin
                        s_d.cnt   = cmd[IDX_W-1:0];
                        s_d.nload = '0;
                        s_d.st    = ST_LOAD;
                        buf_clr   = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (bus_we) begin
                    if (s_q.nload == '0 || in_win) begin
                        buf_we = 1'b1;
                        if (s_q.nload == '0) begin
                            s_d.start = bus_addr;
                            buf_waddr = '0;
                        end else begin
                            buf_waddr = off[IDX_W-1:0];
                        end
                        if (s_q.nload == s_q.cnt) begin
                            s_d.st = ST_CONFIRM;
                        end else begin
                            s_d.nload = s_q.nload + 1'b1;
                        end
                    end else begin
                        s_d.err     = 1'b1;
                        s_d.st      = ST_IDLE;
                        s_d.rd_stat = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (bus_we) begin
                    if (cmd == CMD_CONFIRM && same_blk) begin
                        s_d.st  = ST_PROG;
                        s_d.idx = '0;
                        s_d.tmr = '0;
                    end else begin
                        s_d.err     = 1'b1;
                        s_d.st      = ST_IDLE;
                        s_d.rd_stat = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (s_q.tmr == TMR_LAST) begin
                    arr_we  = 1'b1;
                    s_d.tmr = '0;
                    if (s_q.idx == s_q.cnt) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
                if (bus_we) begin
                    if (cmd == CMD_READARR) begin
                        s_d.rd_stat = 1'b0;
                    end else if (cmd == CMD_CLRSTAT) begin
                        s_d.err = 1'b0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (bus_re) begin
            s_d.rdata = s_q.rd_stat ? stat_word : arr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, rd_stat: 1'b0, err: 1'b0, start: '0, cnt: '0,
                     nload: '0, idx: '0, tmr: '0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_raddr = s_q.idx;
    assign arr_waddr = s_q.start + idx_ext;
    assign arr_wdata = buf_rdata;
    assign bus_rdata = s_q.rdata;
    assign ready_o   = (s_q.st != ST_PROG);
    assign err_o     = s_q.err;
endmodule

// File: rtl/bufprog_flash.sv
module bufprog_flash #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int BUF_DEPTH    = 32,
    parameter int BLK_W        = 6,
    parameter int CYC_PER_WORD = 8,
    localparam int IDX_W       = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ready_o,
    output logic              err_o
);
    logic              buf_clr, buf_we, arr_we;
    logic [IDX_W-1:0]  buf_waddr, buf_raddr;
    logic [DATA_W-1:0] buf_wdata, buf_rdata, arr_wdata, arr_rdata;
    logic [ADDR_W-1:0] arr_waddr;

    bp_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH),
        .BLK_W(BLK_W), .CYC_PER_WORD(CYC_PER_WORD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .ready_o(ready_o), .err_o(err_o),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    bp_wbuf #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .waddr(buf_waddr),
        .wdata(buf_wdata), .raddr(buf_raddr), .rdata(buf_rdata)
    );

    bp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(bus_addr), .rdata(arr_rdata)
    );
endmodule

// File: rtl/bufprog_flash_chk.sv
module bufprog_flash_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              ready_o,
    input logic              err_o
);
    // R6
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> ($past(bus_we) && $past(bus_wdata[7:0]) == 8'hD0));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |=> !ready_o);

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> ($past(bus_we) && $past(bus_wdata[7:0]) == 8'h50));

    // R10
    busy_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && bus_we) |=> !$rose(err_o));

    // R3
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(bus_we));
endmodule

bind bufprog_flash bufprog_flash_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .ready_o(ready_o), .err_o(err_o)
);

// File: tb/bufprog_flash_test.sv
module bufprog_flash_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        ready_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [256];
    logic [15:0] dat [32];
    logic [15:0] rv;

    always #2 clk = ~clk;

    bufprog_flash uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .ready_o(ready_o), .err_o(err_o)
    );

    function automatic logic [15:0] stat(input bit rdy, input bit er);
        logic [15:0] w = '0;
        w[7] = rdy;
        w[4] = er;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic verify_range(input int base, input int n, input string tag);
        wr(8'h00, 16'h00FF);
        for (int i = 0; i <= n; i++) begin
            if (base + i < 256) begin
                rd(8'(base + i), rv);
                chk(tag, rv, model[base + i]);
            end
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", 16'(ready_o), 16'd1);
        chk("R1 err", 16'(err_o), 16'd0);
        rd(8'h05, rv); chk("R1 array erased", rv, 16'hFFFF);

        // R2 setup, status at unrelated address
        wr(8'h40, 16'h00E8);
        rd(8'h13, rv); chk("R2 status after setup", rv, stat(1, 0));
        // count N=4, out-of-order loads
        wr(8'h40, 16'h0003);
        dat[0] = 16'hA5A5; dat[3] = 16'h0F0F; dat[1] = 16'h1234; dat[2] = 16'h8001;
        wr(8'h44, dat[0]); wr(8'h47, dat[3]); wr(8'h45, dat[1]); wr(8'h46, dat[2]);
        rd(8'hC0, rv); chk("R2 status during load", rv, stat(1, 0));
        wr(8'h7F, 16'h00D0);
        // R6 exact busy window: 32 cycles
        chk("R6 busy at start", 16'(ready_o), 16'd0);
        repeat (31) @(negedge clk);
        chk("R6 busy last cycle", 16'(ready_o), 16'd0);
        @(negedge clk);
        chk("R6 ready after 8N", 16'(ready_o), 16'd1);
        rd(8'h00, rv); chk("R6 status ready", rv, stat(1, 0));
        for (int i = 0; i < 4; i++) model[8'h44 + i] &= dat[i];
        verify_range(8'h44, 4, "R7/R8 directed program");

        // R3 count too large
        wr(8'h10, 16'h00E8); wr(8'h10, 16'h0020);
        chk("R3 err on count 0x20", 16'(err_o), 16'd1);
        rd(8'h10, rv); chk("R3 status err", rv, stat(1, 1));
        // R9 persistence
        wr(8'h10, 16'h00FF);
        rd(8'h10, rv); chk("R8 array mode", rv, model[8'h10]);
        chk("R9 err kept after FF", 16'(err_o), 16'd1);
        wr(8'h10, 16'h0050);
        chk("R9 err cleared", 16'(err_o), 16'd0);

        // R4 out-of-block data
        wr(8'h10, 16'h00E8); wr(8'h10, 16'h0001);
        wr(8'h10, 16'h0000); wr(8'h50, 16'h0000);
        chk("R4 err out of block", 16'(err_o), 16'd1);
        wr(8'h00, 16'h0050);
        // R4 offset beyond N
        wr(8'h20, 16'h00E8); wr(8'h20, 16'h0001);
        wr(8'h20, 16'h0000); wr(8'h22, 16'h0000);
        chk("R4 err beyond window", 16'(err_o), 16'd1);
        verify_range(8'h10, 18, "R4 array untouched");
        wr(8'h00, 16'h0050);

        // R5 wrong confirm code and wrong block
        wr(8'h30, 16'h00E8); wr(8'h30, 16'h0000); wr(8'h30, 16'h0000);
        wr(8'h30, 16'h00D1);
        chk("R5 err wrong code", 16'(err_o), 16'd1);
        chk("R5 not busy", 16'(ready_o), 16'd1);
        wr(8'h00, 16'h0050);
        wr(8'h30, 16'h00E8); wr(8'h30, 16'h0000); wr(8'h30, 16'h0000);
        wr(8'h80, 16'h00D0);
        chk("R5 err wrong block", 16'(err_o), 16'd1);
        verify_range(8'h30, 1, "R5 array untouched");

        // R10 commands during busy, with err pending
        wr(8'h90, 16'h00E8); wr(8'h90, 16'h0000); wr(8'h90, 16'h7777);
        wr(8'h90, 16'h00D0);
        chk("R10 busy", 16'(ready_o), 16'd0);
        wr(8'h90, 16'h0050);
        chk("R9 clear during busy", 16'(err_o), 16'd0);
        wr(8'h90, 16'h00E8);
        repeat (8) @(negedge clk);
        chk("R10 ready", 16'(ready_o), 16'd1);
        wr(8'h90, 16'h00AB);
        rd(8'h90, rv); chk("R10 setup ignored while busy", rv, stat(1, 0));
        model[8'h90] &= 16'h7777;
        verify_range(8'h90, 1, "R7 single word");

        // random transactions
        for (int s = 0; s < 30; s++) begin
            int n = $urandom_range(1, 32);
            int blk = $urandom_range(0, 3);
            int st = blk * 64 + $urandom_range(0, 64 - n);
            for (int i = 0; i < n; i++) dat[i] = 16'($urandom) | 16'($urandom);
            wr(8'($urandom), 16'h00E8);
            rd(8'($urandom), rv); chk("R2 random status", rv, stat(1, 0));
            wr(8'($urandom), 16'(n - 1));
            wr(8'(st), dat[0]);
            for (int i = n - 1; i >= 1; i--) wr(8'(st + i), dat[i]);
            wr(8'(blk * 64 + $urandom_range(0, 63)), 16'h00D0);
            rd(8'($urandom), rv); chk("R6 random busy status", rv, stat(0, 0));
            repeat (8 * n - 1) @(negedge clk);
            chk("R6 random ready", 16'(ready_o), 16'd1);
            for (int i = 0; i < n; i++) model[st + i] &= dat[i];
            verify_range(st, n, "R7 random program");
        end

        summary();
    end
endmodule